// File: doc/BRIEF.md
# Cascaded Second-Order-Section IIR Filter

This block is a fixed-point recursive filter built from a chain of biquad sections. Each section is in transposed direct form II and keeps two state registers, which keeps the critical path short. The chain length is fixed at build time. Software selects how many of the sections take part, and the sections past that count pass their input through unchanged. A single gain value in Q format is applied at the input of every active section. The total gain of the chain is therefore that value raised to the number of active sections, so software programs the matching root of the overall gain it wants.

Everything is reached through a 32-bit register slave with strobe, write-enable and acknowledge. A write to the sample register starts one sample down the chain, with one section evaluated per clock. After a fixed latency the output lands in the result register, and a busy flag in the status register stays high while the sample is in flight. Coefficients for each section are loaded through the same port.

Top module: `iir_biquad_chain`

## Requirements
- R1: An access is accepted on a clock edge where `stb_i` is high and `ack_o` is low. `ack_o` is high for exactly the one cycle that follows that edge, so a strobe held high is accepted every second cycle. `ack_o` never rises without an accepted strobe.
- R2: Register map on word addresses. 0x00 is the sample input (write, low DATA_W bits, signed). 0x01 is the result (read, sign-extended to 32 bits). 0x02 holds the active section count minus one (read/write, low $clog2(NSECT) bits, reset NSECT-1). 0x03 is the per-section gain (write-only, reads 0, reset 1.0). 0x04 is status, with bit 0 as busy. Result and status reset to 0.
- R3: A sample write accepted while the block is idle sets busy from the next cycle. Busy stays high for exactly NSECT cycles, and in the last of them the result register takes the chain output. The result never changes while the block is idle.
- R4: A sample write accepted while busy is ignored. The result of the sample in flight is not disturbed.
- R5: Each active section computes y = b0·u + s1, s1' = b1·u − a1·y + s2 and s2' = b2·u − a2·y. Here u is the section's scaled input, and the state updates once per sample.
- R6: In every active section the input is first multiplied by the gain register, giving u = gain·x. The overall gain is gain^(count).
- R7: A section whose index is greater than the programmed count minus one passes its input straight through, with no gain applied. Its two state registers are cleared, so a section that is enabled again starts from zero state.
- R8: Every coefficient or gain product is rounded to the data scale by adding 2^(FRAC_W−1) and shifting right arithmetically by FRAC_W bits.
- R9: Scaled inputs and section outputs saturate to the signed DATA_W range. State registers saturate to DATA_W+GUARD_W bits. None of them wraps.
- R10: Coefficients sit at address 0x40 + 8·section + index, with index 0..4 = b0, b1, b2, a1, a2. They are signed with FRAC_W fractional bits and write-only. They reset to b0 = 1.0 and 0 for the rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stb_i | input | 1 | Access strobe |
| we_i | input | 1 | Write enable for the access |
| adr_i | input | ADDR_W | Word address |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data, registered, valid with ack |
| ack_o | output | 1 | One-cycle acknowledge |

## Verification
The assertions assume that a master keeps `stb_i` and its address and data steady until it sees `ack_o`, then drops the strobe or starts a new access. They also assume that samples are launched only through the sample register, so busy cycles are always counted from an idle state. The bench drives every access from one task that raises the strobe on a falling edge and releases it once the acknowledge is seen. A single scenario holds the strobe high on purpose to show the every-other-cycle acceptance. Coefficient values stay within the Q2.14 range the bench model uses, and the saturation cases push only the products and outputs to full scale.

// File: rtl/iir_pkg.sv
package iir_pkg;
  // Word addresses of the scalar registers
  localparam int A_SAMPLE = 'h00;
  localparam int A_RESULT = 'h01;
  localparam int A_COUNT  = 'h02;
  localparam int A_GAIN   = 'h03;
  localparam int A_STATUS = 'h04;
  // Coefficient window: upper address bits equal to this tag
  localparam int COEF_TAG = 1;
  localparam int NCOEF    = 5;

  typedef enum logic [2:0] {
    C_B0 = 3'd0,
    C_B1 = 3'd1,
    C_B2 = 3'd2,
    C_A1 = 3'd3,
    C_A2 = 3'd4
  } coef_sel_e;
endpackage

// File: rtl/iir_sos_stage.sv
module iir_sos_stage #(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int FRAC_W  = 14,
  parameter int GUARD_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step,
  input  logic                     bypass,
  input  logic signed [DATA_W-1:0] x_in,
  input  logic signed [COEF_W-1:0] gain,
  input  logic signed [COEF_W-1:0] b0,
  input  logic signed [COEF_W-1:0] b1,
  input  logic signed [COEF_W-1:0] b2,
  input  logic signed [COEF_W-1:0] a1,
  input  logic signed [COEF_W-1:0] a2,
  output logic signed [DATA_W-1:0] y_out
);
  localparam int ST_W  = DATA_W + GUARD_W;
  localparam int ACC_W = DATA_W + COEF_W + GUARD_W + 2;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] D_MAX = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] D_MIN = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] S_MAX = {{(ACC_W-ST_W+1){1'b0}}, {(ST_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] S_MIN = {{(ACC_W-ST_W+1){1'b1}}, {(ST_W-1){1'b0}}};

  logic signed [ST_W-1:0]   s1_q, s2_q;
  logic signed [DATA_W-1:0] u_sc, y_sec;
  logic signed [ST_W-1:0]   s1_nx, s2_nx;

  // Product with round-half-up back to data scale
  function automatic logic signed [ACC_W-1:0] mul_rnd(input logic signed [COEF_W-1:0] c,
                                                      input logic signed [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] p;
    p = ACC_W'(c) * v;
    return (p + HALF) >>> FRAC_W;
  endfunction

  function automatic logic signed [DATA_W-1:0] sat_d(input logic signed [ACC_W-1:0] v);
    if (v > D_MAX)      return {1'b0, {(DATA_W-1){1'b1}}};
    else if (v < D_MIN) return {1'b1, {(DATA_W-1){1'b0}}};
    else                return v[DATA_W-1:0];
  endfunction

  function automatic logic signed [ST_W-1:0] sat_s(input logic signed [ACC_W-1:0] v);
    if (v > S_MAX)      return {1'b0, {(ST_W-1){1'b1}}};
    else if (v < S_MIN) return {1'b1, {(ST_W-1){1'b0}}};
    else                return v[ST_W-1:0];
  endfunction

  always_comb begin
    u_sc  = sat_d(mul_rnd(gain, ACC_W'(x_in)));
    y_sec = sat_d(mul_rnd(b0, ACC_W'(u_sc)) + ACC_W'(s1_q));
    s1_nx = sat_s(mul_rnd(b1, ACC_W'(u_sc)) - mul_rnd(a1, ACC_W'(y_sec)) + ACC_W'(s2_q));
    s2_nx = sat_s(mul_rnd(b2, ACC_W'(u_sc)) - mul_rnd(a2, ACC_W'(y_sec)));
    y_out = bypass ? x_in : y_sec;
  end

  always_ff @(posedge clk) begin
    if (rst || bypass) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (step) begin
      s1_q <= s1_nx;
      s2_q <= s2_nx;
    end
  end
endmodule

// File: rtl/iir_bus_regs.sv
module iir_bus_regs
  import iir_pkg::*;
#(
  parameter int NSECT  = 4,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 14,
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          stb_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             adr_i,
  input  logic [31:0]                   dat_i,
  input  logic                          busy,
  input  logic signed [DATA_W-1:0]      result,
  output logic [31:0]                   dat_o,
  output logic                          ack_o,
  output logic                          launch,
  output logic signed [DATA_W-1:0]      sample,
  output logic [$clog2(NSECT)-1:0]      act_last,
  output logic signed [COEF_W-1:0]      gain,
  output logic [NSECT*NCOEF*COEF_W-1:0] coef_flat
);
  localparam int SEC_W = $clog2(NSECT);
  localparam logic signed [COEF_W-1:0] ONE = COEF_W'(1) <<< FRAC_W;

  logic        ack_q;
  logic [31:0] dat_q, rd_mux;
  logic        accept, wr_hit, coef_win;
  logic [2:0]  wsec, widx;

  assign accept   = stb_i & ~ack_q;
  assign wr_hit   = accept & we_i;
  assign coef_win = (adr_i[ADDR_W-1:6] == (ADDR_W-6)'(COEF_TAG));
  assign wsec     = adr_i[5:3];
  assign widx     = adr_i[2:0];
  assign launch   = wr_hit & (adr_i == ADDR_W'(A_SAMPLE)) & ~busy;
  assign sample   = dat_i[DATA_W-1:0];
  assign ack_o    = ack_q;
  assign dat_o    = dat_q;

  always_comb begin
    rd_mux = '0;
    if (adr_i == ADDR_W'(A_RESULT))      rd_mux = {{(32-DATA_W){result[DATA_W-1]}}, result};
    else if (adr_i == ADDR_W'(A_COUNT))  rd_mux = {{(32-SEC_W){1'b0}}, act_last};
    else if (adr_i == ADDR_W'(A_STATUS)) rd_mux = {31'd0, busy};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q    <= 1'b0;
      dat_q    <= '0;
      act_last <= SEC_W'(NSECT - 1);
      gain     <= ONE;
    end else begin
      ack_q <= accept;
      if (accept && !we_i) dat_q <= rd_mux;
      if (wr_hit && adr_i == ADDR_W'(A_COUNT)) act_last <= dat_i[SEC_W-1:0];
      if (wr_hit && adr_i == ADDR_W'(A_GAIN))  gain <= dat_i[COEF_W-1:0];
    end
  end

  // Coefficient bank, one register per section and tap
  for (genvar s = 0; s < NSECT; s++) begin : g_sec
    for (genvar i = 0; i < NCOEF; i++) begin : g_tap
      always_ff @(posedge clk) begin
        if (rst)
          coef_flat[(s*NCOEF+i)*COEF_W +: COEF_W] <= (i == 0) ? ONE : '0;
        else if (wr_hit && coef_win && wsec == 3'(s) && widx == 3'(i))
          coef_flat[(s*NCOEF+i)*COEF_W +: COEF_W] <= dat_i[COEF_W-1:0];
      end
    end
  end
endmodule

// File: rtl/iir_biquad_chain.sv
module iir_biquad_chain
  import iir_pkg::*;
#(
  parameter int NSECT   = 4,
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int FRAC_W  = 14,
  parameter int GUARD_W = 4,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [31:0]       dat_i,
  output logic [31:0]       dat_o,
  output logic              ack_o
);
  localparam int SEC_W = $clog2(NSECT);

  logic                          launch, busy;
  logic signed [DATA_W-1:0]      sample, x_q, result_q;
  logic [SEC_W-1:0]              act_last;
  logic signed [COEF_W-1:0]      gain;
  logic [NSECT*NCOEF*COEF_W-1:0] coef_flat;
  logic [NSECT-1:0]              tok_q;
  logic signed [DATA_W-1:0]      sec_in  [NSECT];
  logic signed [DATA_W-1:0]      sec_out [NSECT];
  logic signed [DATA_W-1:0]      link_q  [NSECT];

  assign busy = |tok_q;

  iir_bus_regs #(
    .NSECT(NSECT), .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .stb_i(stb_i), .we_i(we_i), .adr_i(adr_i), .dat_i(dat_i),
    .busy(busy), .result(result_q), .dat_o(dat_o), .ack_o(ack_o), .launch(launch),
    .sample(sample), .act_last(act_last), .gain(gain), .coef_flat(coef_flat)
  );

  // Token walks one section per clock
  always_ff @(posedge clk) begin
    if (rst) begin
      tok_q    <= '0;
      x_q      <= '0;
      result_q <= '0;
    end else begin
      tok_q <= {tok_q[NSECT-2:0], launch};
      if (launch) x_q <= sample;
      if (tok_q[NSECT-1]) result_q <= sec_out[NSECT-1];
    end
  end

  for (genvar k = 0; k < NSECT; k++) begin : g_chain
    if (k == 0) begin : g_head
      assign sec_in[k] = x_q;
    end else begin : g_link
      assign sec_in[k] = link_q[k-1];
    end

    iir_sos_stage #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .GUARD_W(GUARD_W)
    ) u_sos (
      .clk(clk), .rst(rst), .step(tok_q[k]),
      .bypass(SEC_W'(k) > act_last),
      .x_in(sec_in[k]), .gain(gain),
      .b0(coef_flat[(k*NCOEF+0)*COEF_W +: COEF_W]),
      .b1(coef_flat[(k*NCOEF+1)*COEF_W +: COEF_W]),
      .b2(coef_flat[(k*NCOEF+2)*COEF_W +: COEF_W]),
      .a1(coef_flat[(k*NCOEF+3)*COEF_W +: COEF_W]),
      .a2(coef_flat[(k*NCOEF+4)*COEF_W +: COEF_W]),
      .y_out(sec_out[k])
    );

    always_ff @(posedge clk) begin
      if (rst)           link_q[k] <= '0;
      else if (tok_q[k]) link_q[k] <= sec_out[k];
    end
  end
endmodule

// File: rtl/iir_biquad_chain_chk.sv
module iir_biquad_chain_chk #(
  parameter int NSECT  = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              stb_i,
  input logic              ack_o,
  input logic              busy,
  input logic [NSECT-1:0]  tok_q,
  input logic [DATA_W-1:0] result_q
);
  int unsigned busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= 0;
    else              busy_cnt <= busy_cnt + 1;
  end

  a_r1_ack_follows_strobe: assert property (@(posedge clk) disable iff (rst)
    (stb_i && !ack_o) |=> ack_o);
  a_r1_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);
  a_r1_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
    !stb_i |=> !ack_o);
  a_r3_single_token: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tok_q));
  a_r3_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_cnt == NSECT));
  a_r3_result_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(result_q));
endmodule

bind iir_biquad_chain iir_biquad_chain_chk #(.NSECT(NSECT), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .stb_i(stb_i), .ack_o(ack_o),
  .busy(busy), .tok_q(tok_q), .result_q(result_q)
);

// File: tb/tb_iir_biquad_chain.sv
module tb_iir_biquad_chain;
  localparam int NSECT  = 4;
  localparam int FRAC_W = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stb = 1'b0;
  logic        we  = 1'b0;
  logic [7:0]  adr = '0;
  logic [31:0] wdat = '0;
  logic [31:0] rdat;
  logic        ack;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // bench-side shadow of the programmed values and the filter state
  longint g_m;
  longint cf_m [NSECT][5];
  int     last_m;
  longint s1_m [NSECT];
  longint s2_m [NSECT];

  always #4 clk = ~clk;

  iir_biquad_chain dut (
    .clk(clk), .rst(rst), .stb_i(stb), .we_i(we), .adr_i(adr),
    .dat_i(wdat), .dat_o(rdat), .ack_o(ack)
  );

  function automatic longint rnd(longint p);
    return (p + (64'sd1 <<< (FRAC_W - 1))) >>> FRAC_W;
  endfunction

  function automatic longint sat(longint v, int w);
    longint hi = (64'sd1 <<< (w - 1)) - 1;
    longint lo = -(64'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint model_step(longint x);
    longint v = x;
    for (int k = 0; k < NSECT; k++) begin
      if (k > last_m) begin
        s1_m[k] = 0;
        s2_m[k] = 0;
      end else begin
        longint u, y, n1, n2;
        u  = sat(rnd(g_m * v), 16);
        y  = sat(rnd(cf_m[k][0] * u) + s1_m[k], 16);
        n1 = sat(rnd(cf_m[k][1] * u) - rnd(cf_m[k][3] * y) + s2_m[k], 20);
        n2 = sat(rnd(cf_m[k][2] * u) - rnd(cf_m[k][4] * y), 20);
        s1_m[k] = n1;
        s2_m[k] = n2;
        v = y;
      end
    end
    return v;
  endfunction

  task automatic check(string req, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] q);
    @(negedge clk);
    stb = 1'b1; we = w; adr = a; wdat = d;
    @(negedge clk);
    while (!ack) @(negedge clk);
    q = rdat;
    stb = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input longint d);
    logic [31:0] q;
    bus(1'b1, a, 32'(d), q);
    if (a == 8'h02) last_m = int'(d) & (NSECT - 1);
    if (a == 8'h03) g_m = longint'($signed(16'(d)));
    if (a >= 8'h40 && a[2:0] < 3'd5) cf_m[a[5:3]][a[2:0]] = longint'($signed(16'(d)));
  endtask

  task automatic rd(input logic [7:0] a, output longint v);
    logic [31:0] q;
    bus(1'b0, a, 32'd0, q);
    v = longint'($signed(q));
  endtask

  task automatic push(string req, longint x);
    longint got, exp;
    wr(8'h00, x & 64'hFFFF);
    exp = model_step(x);
    repeat (NSECT + 2) @(negedge clk);
    rd(8'h01, got);
    check(req, got, exp);
  endtask

  task automatic set_coef(int s, longint b0, longint b1, longint b2, longint a1, longint a2);
    wr(8'(8'h40 + s * 8 + 0), b0 & 64'hFFFF);
    wr(8'(8'h40 + s * 8 + 1), b1 & 64'hFFFF);
    wr(8'(8'h40 + s * 8 + 2), b2 & 64'hFFFF);
    wr(8'(8'h40 + s * 8 + 3), a1 & 64'hFFFF);
    wr(8'(8'h40 + s * 8 + 4), a2 & 64'hFFFF);
  endtask

  task automatic t_reset;
    longint v;
    rd(8'h01, v); check("R2 result reset", v, 0);
    rd(8'h02, v); check("R2 count reset", v, NSECT - 1);
    rd(8'h04, v); check("R2 status reset", v, 0);
    rd(8'h03, v); check("R2 gain write-only", v, 0);
  endtask

  task automatic t_ack;
    @(negedge clk);
    stb = 1'b1; we = 1'b0; adr = 8'h02;
    @(negedge clk); check("R1 ack after strobe", ack, 1);
    check("R1 read data with ack", rdat, NSECT - 1);
    @(negedge clk); check("R1 ack single cycle", ack, 0);
    @(negedge clk); check("R1 held strobe re-accepted", ack, 1);
    stb = 1'b0;
    @(negedge clk); check("R1 no ack without strobe", ack, 0);
  endtask

  task automatic t_passthrough;
    push("R3 unity chain positive", 1000);
    push("R3 unity chain negative", -12345);
  endtask

  task automatic t_gain;
    wr(8'h03, 8192);
    push("R6 gain per section, all active", 1000);
    push("R8 rounding of odd product", 1001);
    wr(8'h02, 0);
    push("R7 one active section gain once", 1000);
    wr(8'h03, 16384);
  endtask

  task automatic t_busy_ignore;
    longint v, exp;
    wr(8'h02, NSECT - 1);
    wr(8'h00, 2000);
    exp = model_step(2000);
    rd(8'h04, v); check("R3 busy while processing", v, 1);
    wr(8'h00, 77);
    repeat (NSECT + 2) @(negedge clk);
    rd(8'h04, v); check("R3 busy clears", v, 0);
    rd(8'h01, v); check("R4 write while busy ignored", v, exp);
  endtask

  task automatic t_bypass_state;
    // section 1 carries feedback, section 0 unity
    set_coef(1, 8192, 4096, 2048, -8192, 4096);
    wr(8'h02, 1);
    push("R10 section 1 coefficients", 8000);
    push("R5 section 1 state carries", 0);
    wr(8'h02, 0);
    push("R7 bypassed section passes input", 100);
    wr(8'h02, 1);
    push("R7 re-enabled section starts from zero state", 0);
    set_coef(1, 16384, 0, 0, 0, 0);
  endtask

  task automatic t_impulse;
    set_coef(0, 8192, 4096, 2048, -8192, 4096);
    wr(8'h02, 1);
    push("R5 impulse y0", 8000);
    for (int n = 1; n < 7; n++) push("R5 impulse tail", 0);
    push("R5 step after impulse", -3000);
  endtask

  task automatic t_saturate;
    set_coef(0, 32767, 0, 0, 0, 0);
    wr(8'h02, 0);
    push("R9 positive saturation", 30000);
    push("R9 negative saturation", -30000);
    push("R9 in range below limit", 1000);
    set_coef(0, 16384, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    g_m = 16384;
    last_m = NSECT - 1;
    for (int k = 0; k < NSECT; k++) begin
      s1_m[k] = 0; s2_m[k] = 0;
      cf_m[k][0] = 16384;
      for (int i = 1; i < 5; i++) cf_m[k][i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_ack;
    t_passthrough;
    t_gain;
    t_busy_ignore;
    t_bypass_state;
    t_impulse;
    t_saturate;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule